// File: doc/BRIEF.md
# Host Bus Access Decoder with Refresh Arbitration

This block sits between a 16-bit host bus and the storage of a display controller. Every host cycle addresses a 128K-byte window. The window holds two regions. The low region maps contiguously onto an embedded single-port display memory. The top 128 bytes map onto a small register file. Any address that falls between the two regions is an empty hole.

The display memory is shared with a refresh engine that reads pixels on a periodic schedule. Refresh reads always take the memory port. A host access that collides with a refresh slot waits one extra memory cycle. The host is held with an active-low wait output for as long as its access is pending. It may drop its strobes only after that wait output has gone high again.

The memory size is a parameter. The production setting is 81920 bytes; the smaller default keeps elaboration light. A two-stage synchronizer releases the asynchronous reset in step with the clock.

Top module: `hbus_arbiter`

## Requirements
- R1: A byte address below MEM_BYTES selects memory word address[RAM_AW:1]. A byte address at or above 2^17-128 selects register address[6:1], one of 64 16-bit registers. Data written to either region reads back unchanged.
- R2: Reset clears all 64 registers to zero and drops any access in progress. With no strobe applied, host_wait_n reads 1 during and after reset.
- R3: A byte address in the hole, at or above MEM_BYTES and below 2^17-128, reads as 0x0000. A write to the hole changes no memory word and no register. Its wait timing is the same as for a register access.
- R4: On a write, host_be_n[0] low enables bits 7:0 and host_be_n[1] low enables bits 15:8. A lane whose strobe is high keeps its old value, in memory and in registers alike.
- R5: An access starts when host_cs_n is low and host_rd_n or host_wr_n is low. host_wait_n goes low in that same cycle. Without contention it returns high after the third rising edge, giving three low samples at the falling edges. host_wait_n is never low while no access is presented.
- R6: ref_gnt is high in every cycle in which ref_req is high. ref_rdata shows the addressed memory word in the following cycle. A host memory access is never issued in a cycle with ref_req high, so a collision adds exactly one wait cycle (four low samples).
- R7: Register and hole accesses never wait for refresh. A refresh slot during such an access leaves it at three low samples.
- R8: Read data is valid on host_rdata from the first cycle that host_wait_n is high. It stays unchanged until the host releases its strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_be_n | input | 2 | Byte write enables, active low, bit 0 = bits 7:0 |
| host_addr | input | 17 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_wait_n | output | 1 | Hold-off to host, low while access pending |
| ref_req | input | 1 | Refresh read request |
| ref_addr | input | RAM_AW (11) | Refresh memory word address |
| ref_gnt | output | 1 | Refresh grant |
| ref_rdata | output | 16 | Refresh read data, one cycle after grant |

## Verification
The assertions rely on three things about the host. It keeps its strobes, address and data steady until host_wait_n is high. It never asserts read and write together. The refresh engine never requests in two consecutive cycles, and the one-cycle delay bound depends on that spacing. The stimulus drives one access at a time. It holds every access until one cycle after release, lets each refresh pulse last exactly one cycle, and drops the strobes together with reset when it aborts an access.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_LATCH = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_MEM  = 2'd0,
    TGT_REG  = 2'd1,
    TGT_NONE = 2'd2
  } tgt_e;

endpackage

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int MEM_BYTES = 4096,
  parameter int REG_BYTES = 128,
  parameter int LANES     = 2,
  localparam int LANE_SH  = (LANES > 1) ? $clog2(LANES) : 0,
  localparam int RAM_AW   = $clog2(MEM_BYTES / LANES),
  localparam int REG_AW   = $clog2(REG_BYTES / LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [RAM_AW-1:0] mem_idx,
  output logic [REG_AW-1:0] reg_idx
);

  localparam logic [ADDR_W:0] MEM_END  = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W:0] REG_BASE = (ADDR_W+1)'((2 ** ADDR_W) - REG_BYTES);

  logic [ADDR_W:0] addr_x;

  always_comb begin
    addr_x = {1'b0, addr};
    if (addr_x < MEM_END) begin
      tgt = TGT_MEM;
    end else if (addr_x >= REG_BASE) begin
      tgt = TGT_REG;
    end else begin
      tgt = TGT_NONE;
    end
  end

  assign mem_idx = addr[RAM_AW+LANE_SH-1:LANE_SH];
  assign reg_idx = addr[REG_AW+LANE_SH-1:LANE_SH];

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_req,
  input  logic [LANES-1:0]  be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  tgt_e              lat_tgt,
  input  logic              ref_req,
  output logic              wait_n,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [LANES-1:0]  lat_be_n,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              lat_wr,
  output logic              mem_go,
  output logic              reg_we,
  output logic              capture
);

  seq_state_e state_q, state_d;
  logic       lat_en;
  logic       arb_pass;

  // request latch enable: only a fresh access from idle
  assign lat_en   = (state_q == ST_IDLE) && start;
  // memory accesses yield to refresh; other targets never do
  assign arb_pass = (lat_tgt != TGT_MEM) || !ref_req;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start)    state_d = ST_ARB;
      ST_ARB:   if (arb_pass) state_d = ST_LATCH;
      ST_LATCH:               state_d = ST_DONE;
      ST_DONE:  if (!start)   state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_be_n  <= '1;
      lat_wdata <= '0;
      lat_wr    <= 1'b0;
    end else if (lat_en) begin
      lat_addr  <= addr;
      lat_be_n  <= be_n;
      lat_wdata <= wdata;
      lat_wr    <= wr_req;
    end
  end

  assign mem_go  = (state_q == ST_ARB) && (lat_tgt == TGT_MEM) && !ref_req;
  assign reg_we  = (state_q == ST_ARB) && (lat_tgt == TGT_REG) && lat_wr;
  assign capture = (state_q == ST_LATCH);
  assign wait_n  = !(lat_en || (state_q == ST_ARB) || (state_q == ST_LATCH));

endmodule

// File: rtl/hbus_spram.sv
module hbus_spram
  import hbus_pkg::*;
#(
  parameter int WORDS  = 2048,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] cells [WORDS];
    logic [BYTE_W-1:0] q_lane;
    logic              wr_lane;

    assign wr_lane = en && we && be[l];

    always_ff @(posedge clk) begin
      if (wr_lane) begin
        cells[addr] <= wdata[l*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_lane <= '0;
      end else if (en) begin
        q_lane <= cells[addr];
      end
    end

    assign rdata[l*BYTE_W +: BYTE_W] = q_lane;
  end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] cells [WORDS];
    logic              wr_lane;

    assign wr_lane = we && be[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) begin
          cells[i] <= '0;
        end
      end else if (wr_lane) begin
        cells[idx] <= wdata[l*BYTE_W +: BYTE_W];
      end
    end

    assign rdata[l*BYTE_W +: BYTE_W] = cells[idx];
  end

endmodule

// File: rtl/hbus_arbiter.sv
module hbus_arbiter
  import hbus_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int MEM_BYTES = 4096,
  parameter int REG_BYTES = 128,
  localparam int LANES    = DATA_W / BYTE_W,
  localparam int RAM_AW   = $clog2(MEM_BYTES / LANES),
  localparam int REG_AW   = $clog2(REG_BYTES / LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [LANES-1:0]  host_be_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_wait_n,
  input  logic              ref_req,
  input  logic [RAM_AW-1:0] ref_addr,
  output logic              ref_gnt,
  output logic [DATA_W-1:0] ref_rdata
);

  localparam int RAM_WORDS = MEM_BYTES / LANES;
  localparam int REG_WORDS = REG_BYTES / LANES;

  logic              rst_i_n;
  logic              start;
  logic [ADDR_W-1:0] lat_addr;
  logic [LANES-1:0]  lat_be_n;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_wr;
  tgt_e              lat_tgt;
  logic [RAM_AW-1:0] mem_idx;
  logic [REG_AW-1:0] reg_idx;
  logic              mem_go;
  logic              reg_we;
  logic              capture;
  logic              mem_en;
  logic              mem_we;
  logic [RAM_AW-1:0] mem_addr;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  hbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign start = !host_cs_n && (!host_rd_n || !host_wr_n);

  hbus_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .wr_req    (!host_wr_n),
    .be_n      (host_be_n),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .lat_tgt   (lat_tgt),
    .ref_req   (ref_req),
    .wait_n    (host_wait_n),
    .lat_addr  (lat_addr),
    .lat_be_n  (lat_be_n),
    .lat_wdata (lat_wdata),
    .lat_wr    (lat_wr),
    .mem_go    (mem_go),
    .reg_we    (reg_we),
    .capture   (capture)
  );

  hbus_decode #(
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES),
    .REG_BYTES (REG_BYTES),
    .LANES     (LANES)
  ) u_dec (
    .addr    (lat_addr),
    .tgt     (lat_tgt),
    .mem_idx (mem_idx),
    .reg_idx (reg_idx)
  );

  // refresh owns the port whenever it asks
  assign ref_gnt  = ref_req;
  assign mem_en   = ref_req || mem_go;
  assign mem_we   = mem_go && lat_wr;
  assign mem_addr = ref_req ? ref_addr : mem_idx;

  hbus_spram #(
    .WORDS  (RAM_WORDS),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (mem_en),
    .we    (mem_we),
    .be    (~lat_be_n),
    .addr  (mem_addr),
    .wdata (lat_wdata),
    .rdata (mem_q)
  );

  hbus_regfile #(
    .WORDS  (REG_WORDS),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (reg_we),
    .be    (~lat_be_n),
    .idx   (reg_idx),
    .wdata (lat_wdata),
    .rdata (reg_q)
  );

  always_comb begin
    case (lat_tgt)
      TGT_MEM: rdata_d = mem_q;
      TGT_REG: rdata_d = reg_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign ref_rdata  = mem_q;

endmodule

// File: rtl/hbus_arbiter_chk.sv
module hbus_arbiter_chk #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int MEM_BYTES = 4096,
  parameter int REG_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs_n,
  input logic              host_rd_n,
  input logic              host_wr_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_wait_n,
  input logic              ref_req,
  input logic              mem_go
);

  localparam logic [ADDR_W:0] HOLE_LO = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W:0] HOLE_HI = (ADDR_W+1)'((2 ** ADDR_W) - REG_BYTES);

  logic       acc_on;
  logic       rd_on;
  logic       in_hole;
  logic [2:0] lo_cnt;

  assign acc_on  = !host_cs_n && (!host_rd_n || !host_wr_n);
  assign rd_on   = !host_cs_n && !host_rd_n && host_wr_n;
  assign in_hole = ({1'b0, host_addr} >= HOLE_LO) && ({1'b0, host_addr} < HOLE_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (!host_wait_n) begin
      if (lo_cnt != 3'd7) lo_cnt <= lo_cnt + 3'd1;
    end else begin
      lo_cnt <= '0;
    end
  end

  AST_WAIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wait_n |-> acc_on); // R5

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wait_n |-> (lo_cnt < 3'd4)); // R6

  AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !mem_go); // R6

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wait_n && rd_on && in_hole) |-> (host_rdata == '0)); // R3

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wait_n && $past(host_wait_n) && rd_on && $past(rd_on)) |-> $stable(host_rdata)); // R8

endmodule

bind hbus_arbiter hbus_arbiter_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MEM_BYTES (MEM_BYTES),
  .REG_BYTES (REG_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_cs_n   (host_cs_n),
  .host_rd_n   (host_rd_n),
  .host_wr_n   (host_wr_n),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .host_wait_n (host_wait_n),
  .ref_req     (ref_req),
  .mem_go      (mem_go)
);

// File: tb/hbus_arbiter_tb_top.sv
`timescale 1ns/1ps
module hbus_arbiter_tb_top;

  localparam int MEM_BYTES = 4096;
  localparam int RAM_AW    = 11;
  localparam logic [16:0] REG0 = 17'h1FF80;

  logic        clk;
  logic        rst_n;
  logic        host_cs_n;
  logic        host_rd_n;
  logic        host_wr_n;
  logic [1:0]  host_be_n;
  logic [16:0] host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_wait_n;
  logic        ref_req;
  logic [RAM_AW-1:0] ref_addr;
  logic        ref_gnt;
  logic [15:0] ref_rdata;

  hbus_arbiter #(.MEM_BYTES(MEM_BYTES)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cs_n   (host_cs_n),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .host_be_n   (host_be_n),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_wait_n (host_wait_n),
    .ref_req     (ref_req),
    .ref_addr    (ref_addr),
    .ref_gnt     (ref_gnt),
    .ref_rdata   (ref_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    bit          chk_data;
    logic [15:0] data;
    int          waits;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk;
  int          n_bad;
  bit          finished;
  logic [15:0] mdl_mem [MEM_BYTES/2];
  logic [15:0] mdl_reg [64];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tgt_of(logic [16:0] a);
    if (a < 17'(MEM_BYTES)) return 0;
    if (a >= REG0) return 1;
    return 2;
  endfunction

  // monitor: count low wait samples, compare when the access completes
  initial begin
    int  lo = 0;
    bit  seen = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || host_cs_n || (host_rd_n && host_wr_n)) begin
        lo = 0;
        seen = 0;
      end else if (!seen) begin
        if (!host_wait_n) begin
          lo++;
        end else begin
          exp_t e;
          seen = 1;
          if (sb_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
          end else begin
            e = sb_q.pop_front();
            check({e.tag, " wait samples (R5)"}, 32'(lo), 32'(e.waits));
            if (e.chk_data) check({e.tag, " read data"}, {16'h0, host_rdata}, {16'h0, e.data});
          end
        end
      end
    end
  end

  task automatic xfer(bit wr, logic [16:0] a, logic [15:0] d, logic [1:0] ben,
                      bit collide, logic [RAM_AW-1:0] raddr, string tag);
    exp_t        e;
    int          t;
    logic [15:0] cur;
    t = tgt_of(a);
    cur = (t == 0) ? mdl_mem[a[RAM_AW:1]] : (t == 1) ? mdl_reg[a[6:1]] : 16'h0000;
    e.tag = tag;
    e.chk_data = !wr;
    e.data = cur;
    e.waits = (collide && t == 0) ? 4 : 3;
    if (wr) begin
      for (int l = 0; l < 2; l++) begin
        if (!ben[l]) cur[l*8 +: 8] = d[l*8 +: 8];
      end
      if (t == 0) mdl_mem[a[RAM_AW:1]] = cur;
      if (t == 1) mdl_reg[a[6:1]] = cur;
    end
    sb_q.push_back(e);
    @(posedge clk); #1;
    host_cs_n = 1'b0;
    host_rd_n = wr;
    host_wr_n = !wr;
    host_addr = a;
    host_wdata = d;
    host_be_n = ben;
    @(posedge clk); #1;
    if (collide) begin
      ref_req = 1'b1;
      ref_addr = raddr;
      #0.5;
      check("R6 ref_gnt on request", {31'h0, ref_gnt}, 32'd1);
    end
    @(posedge clk); #1;
    if (collide) begin
      check("R6 refresh read data", {16'h0, ref_rdata}, {16'h0, mdl_mem[raddr]});
      ref_req = 1'b0;
    end
    while (!host_wait_n) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    if (!wr) check({tag, " R8 data held to release"}, {16'h0, host_rdata}, {16'h0, e.data});
    host_cs_n = 1'b1;
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mdl_reg[i] = 16'h0000;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 0;
    rst_n = 1'b0;
    host_cs_n = 1'b1;
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
    host_be_n = 2'b11;
    host_addr = '0;
    host_wdata = '0;
    ref_req = 1'b0;
    ref_addr = '0;
    for (int i = 0; i < 64; i++) mdl_reg[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 wait_n high in reset", {31'h0, host_wait_n}, 32'd1);
    do_reset();
    @(negedge clk);
    check("R2 wait_n high after reset", {31'h0, host_wait_n}, 32'd1);
    check("R2 host_rdata zero after reset", {16'h0, host_rdata}, 32'h0);

    // R1 memory region, contiguous words and top word
    xfer(1, 17'h00000, 16'hA5C3, 2'b00, 0, '0, "R1 mem wr0");
    xfer(1, 17'h00002, 16'h1357, 2'b00, 0, '0, "R1 mem wr1");
    xfer(1, 17'h00004, 16'h2468, 2'b00, 0, '0, "R1 mem wr2");
    xfer(1, 17'(MEM_BYTES - 2), 16'h7E81, 2'b00, 0, '0, "R1 mem wr top");
    xfer(0, 17'h00000, '0, 2'b11, 0, '0, "R1 mem rd0");
    xfer(0, 17'h00002, '0, 2'b11, 0, '0, "R1 mem rd1");
    xfer(0, 17'h00004, '0, 2'b11, 0, '0, "R1 mem rd2");
    xfer(0, 17'(MEM_BYTES - 2), '0, 2'b11, 0, '0, "R1 mem rd top");

    // R1 register window edges
    xfer(1, REG0, 16'hC0DE, 2'b00, 0, '0, "R1 reg wr first");
    xfer(1, 17'h1FFFE, 16'hF00D, 2'b00, 0, '0, "R1 reg wr last");
    xfer(0, REG0, '0, 2'b11, 0, '0, "R1 reg rd first");
    xfer(0, 17'h1FFFE, '0, 2'b11, 0, '0, "R1 reg rd last");

    // R4 byte lanes in memory and registers
    xfer(1, 17'h00010, 16'h1111, 2'b00, 0, '0, "R4 mem full");
    xfer(1, 17'h00010, 16'hABCD, 2'b10, 0, '0, "R4 mem low lane");
    xfer(0, 17'h00010, '0, 2'b11, 0, '0, "R4 mem low lane rd");
    xfer(1, 17'h1FF82, 16'h1234, 2'b00, 0, '0, "R4 reg full");
    xfer(1, 17'h1FF82, 16'hABCD, 2'b01, 0, '0, "R4 reg high lane");
    xfer(0, 17'h1FF82, '0, 2'b11, 0, '0, "R4 reg high lane rd");

    // R3 hole: reads zero, writes land nowhere
    xfer(1, 17'(MEM_BYTES), 16'hDEAD, 2'b00, 0, '0, "R3 hole wr low");
    xfer(1, 17'h1FF7E, 16'hBEEF, 2'b00, 0, '0, "R3 hole wr high");
    xfer(0, 17'(MEM_BYTES), '0, 2'b11, 0, '0, "R3 hole rd low");
    xfer(0, 17'h1FF7E, '0, 2'b11, 0, '0, "R3 hole rd high");
    xfer(0, 17'h00000, '0, 2'b11, 0, '0, "R3 mem word0 untouched");
    xfer(0, 17'h1FFFE, '0, 2'b11, 0, '0, "R3 reg last untouched");

    // R6 refresh collisions on memory
    xfer(0, 17'h00002, '0, 2'b11, 1, 11'd2, "R6 mem rd collide");
    xfer(1, 17'h00020, 16'h5A5A, 2'b00, 1, 11'd0, "R6 mem wr collide");
    xfer(0, 17'h00020, '0, 2'b11, 1, 11'd8, "R6 mem rd back collide");

    // R7 refresh does not delay registers or hole
    xfer(0, REG0, '0, 2'b11, 1, 11'd1, "R7 reg rd refresh");
    xfer(1, 17'h1FF90, 16'h0F0F, 2'b00, 1, 11'd2, "R7 reg wr refresh");
    xfer(0, 17'h1FF90, '0, 2'b11, 0, '0, "R7 reg rd back");
    xfer(0, 17'h01800, '0, 2'b11, 1, 11'd0, "R7 hole rd refresh");

    // R2 reset clears registers and drops a pending access
    xfer(1, 17'h1FF84, 16'hBEEF, 2'b00, 0, '0, "R2 reg preload");
    @(posedge clk); #1;
    host_cs_n = 1'b0;
    host_rd_n = 1'b0;
    host_addr = 17'h1FF84;
    @(posedge clk); #1;
    rst_n = 1'b0;
    host_cs_n = 1'b1;
    host_rd_n = 1'b1;
    @(negedge clk);
    check("R2 wait_n high after abort", {31'h0, host_wait_n}, 32'd1);
    for (int i = 0; i < 64; i++) mdl_reg[i] = 16'h0000;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 wait_n high after release", {31'h0, host_wait_n}, 32'd1);
    xfer(0, 17'h1FF84, '0, 2'b11, 0, '0, "R2 reg cleared a");
    xfer(0, REG0, '0, 2'b11, 0, '0, "R2 reg cleared b");
    xfer(0, 17'h00004, '0, 2'b11, 0, '0, "R1 mem after reset");

    repeat (4) @(posedge clk);
    check("scoreboard drained", 32'(sb_q.size()), 32'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule